// File: doc/BRIEF.md
# Condition Flag Register and Instruction Predication

This block keeps the negative, zero, carry and overflow flags of a 32-bit load-store core. For every issued instruction it evaluates a 4-bit condition against the stored flags. It reports whether the instruction may retire, and it gates the register-writeback and program-counter-write requests that decode raises. The adder, the shifter and the register file sit outside the block. From them it receives the result word, the adder carry or borrow, the signed-overflow indication and the shifter carry. Decode supplies the operation class, the set-flags bit and the condition field.

A flag update is written on the clock edge that ends the instruction's cycle. The condition of the next instruction therefore sees the new flags. The condition check and the gated enables are combinational from the inputs and the stored flags. Compare-class operations always update the flags when their condition passes. They never assert either write enable. All other classes touch the flags only when the set-flags bit is high.

Top module: `nzcv_predicate`

## Requirements
- R1: After reset, `o_nzcv` reads 0000, with bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V.
- R2: A passing instruction of class ADD (0), SUB (1) or LOGIC (2 or 7) with `i_set_flags` low leaves `o_nzcv` unchanged, and its requested writes are still enabled.
- R3: On every flag update, N takes bit 31 of `i_result`, and Z is 1 exactly when all 32 bits of `i_result` are zero.
- R4: On ADD (0) and CMN (4), C takes `i_carry` and V takes `i_overflow`. For example, 0xFFFFFFFF+1 gives NZCV 0110, and 0x7FFFFFFF+1 gives NZCV 1001.
- R5: On SUB (1) and CMP (3), `i_carry` is a borrow and C takes its inverse, while V takes `i_overflow`. For example, 0-1 (result 0xFFFFFFFF, borrow 1) gives NZCV 1000.
- R6: On LOGIC (2, 7), TST (5) and TEQ (6), C takes `i_shift_carry` and V keeps its previous value.
- R7: The compare classes CMP, CMN, TST and TEQ update the flags whenever their condition passes, whatever `i_set_flags` is, and never assert `o_reg_wr_en` or `o_pc_wr_en`.
- R8: Condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). `o_pass` is high when the code's test holds on the current flags.
- R9: Code 14 always passes and code 15 never passes.
- R10: When the condition fails, `o_reg_wr_en` and `o_pc_wr_en` are low and the flags do not change, even when `i_set_flags` is set.
- R11: With `i_valid` low, `o_pass` and both enables are low and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | An instruction is presented this cycle |
| i_class | input | 3 | Operation class: 0 ADD, 1 SUB, 2 LOGIC, 3 CMP, 4 CMN, 5 TST, 6 TEQ, 7 LOGIC |
| i_set_flags | input | 1 | Set-flags request for non-compare classes |
| i_cond | input | 4 | Condition code |
| i_result | input | DW | ALU result word |
| i_carry | input | 1 | Adder carry-out (add classes) or borrow (subtract classes) |
| i_overflow | input | 1 | Signed overflow from the adder |
| i_shift_carry | input | 1 | Shifter carry-out used by logical classes |
| i_reg_wr_req | input | 1 | Decode requests a destination register write |
| i_pc_wr_req | input | 1 | Decode requests a program-counter write |
| o_nzcv | output | 4 | Stored flags, N in bit 3 down to V in bit 0 |
| o_pass | output | 1 | Instruction is valid and its condition holds |
| o_reg_wr_en | output | 1 | Gated register writeback enable |
| o_pc_wr_en | output | 1 | Gated program-counter write enable |

## Verification
A corrupted flag bit is visible on `o_nzcv` one cycle after the update that produced it. On the very next predicated instruction it also shows up as a wrong `o_pass` and wrong write enables. For that reason, every flag pattern the result, carry and overflow inputs can reach is loaded first, and then probed with all sixteen condition codes. The sequences also include updates that must be blocked by a failed condition, by an idle cycle or by a clear set-flags bit. This exposes a leaked update on the cycle right after it happens.

// File: rtl/nzcv_predicate.sv
module nzcv_predicate #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          i_valid,
  input  logic [2:0]    i_class,
  input  logic          i_set_flags,
  input  logic [3:0]    i_cond,
  input  logic [DW-1:0] i_result,
  input  logic          i_carry,
  input  logic          i_overflow,
  input  logic          i_shift_carry,
  input  logic          i_reg_wr_req,
  input  logic          i_pc_wr_req,
  output logic [3:0]    o_nzcv,
  output logic          o_pass,
  output logic          o_reg_wr_en,
  output logic          o_pc_wr_en
);

  localparam logic [2:0] C_ADD = 3'd0, C_SUB = 3'd1, C_CMP = 3'd3,
                         C_CMN = 3'd4, C_TST = 3'd5, C_TEQ = 3'd6;

  logic [3:0] flags, flags_nxt;
  logic       f_n, f_z, f_c, f_v;
  logic       cond_ok, is_cmp, is_add, is_sub, upd;

  assign {f_n, f_z, f_c, f_v} = flags;

  always_comb begin
    unique case (i_cond)
      4'd0:    cond_ok = f_z;
      4'd1:    cond_ok = !f_z;
      4'd2:    cond_ok = f_c;
      4'd3:    cond_ok = !f_c;
      4'd4:    cond_ok = f_n;
      4'd5:    cond_ok = !f_n;
      4'd6:    cond_ok = f_v;
      4'd7:    cond_ok = !f_v;
      4'd8:    cond_ok = f_c && !f_z;
      4'd9:    cond_ok = !f_c || f_z;
      4'd10:   cond_ok = f_n == f_v;
      4'd11:   cond_ok = f_n != f_v;
      4'd12:   cond_ok = !f_z && (f_n == f_v);
      4'd13:   cond_ok = f_z || (f_n != f_v);
      4'd14:   cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  assign is_cmp = (i_class == C_CMP) || (i_class == C_CMN) ||
                  (i_class == C_TST) || (i_class == C_TEQ);
  assign is_add = (i_class == C_ADD) || (i_class == C_CMN);
  assign is_sub = (i_class == C_SUB) || (i_class == C_CMP);

  assign o_pass      = i_valid && cond_ok;
  assign upd         = o_pass && (i_set_flags || is_cmp);
  assign o_reg_wr_en = o_pass && i_reg_wr_req && !is_cmp;
  assign o_pc_wr_en  = o_pass && i_pc_wr_req && !is_cmp;

  always_comb begin
    flags_nxt[3] = i_result[DW-1];
    flags_nxt[2] = ~|i_result;
    if (is_add)      flags_nxt[1] = i_carry;
    else if (is_sub) flags_nxt[1] = !i_carry;
    else             flags_nxt[1] = i_shift_carry;
    flags_nxt[0] = (is_add || is_sub) ? i_overflow : f_v;
  end

  always_ff @(posedge clk) begin
    if (rst)      flags <= 4'b0000;
    else if (upd) flags <= flags_nxt;
  end

  assign o_nzcv = flags;

endmodule

module nzcv_predicate_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          i_valid,
  input logic [2:0]    i_class,
  input logic          i_set_flags,
  input logic [3:0]    i_cond,
  input logic [DW-1:0] i_result,
  input logic          i_carry,
  input logic          i_overflow,
  input logic          i_shift_carry,
  input logic          i_reg_wr_req,
  input logic          i_pc_wr_req,
  input logic [3:0]    o_nzcv,
  input logic          o_pass,
  input logic          o_reg_wr_en,
  input logic          o_pc_wr_en
);

  logic cmp_cls, logic_cls;
  assign cmp_cls   = (i_class >= 3'd3) && (i_class <= 3'd6);
  assign logic_cls = (i_class == 3'd2) || (i_class == 3'd5) ||
                     (i_class == 3'd6) || (i_class == 3'd7);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!i_valid || !o_pass || (!i_set_flags && !cmp_cls)) |=> $stable(o_nzcv));

  p_nz_r3: assert property (@(posedge clk) disable iff (rst)
    (o_pass && (i_set_flags || cmp_cls)) |=>
      (o_nzcv[3] == $past(i_result[DW-1])) && (o_nzcv[2] == ($past(i_result) == '0)));

  p_vkeep_r6: assert property (@(posedge clk) disable iff (rst)
    (o_pass && logic_cls && (i_set_flags || cmp_cls)) |=> $stable(o_nzcv[0]));

  p_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_cls |-> (!o_reg_wr_en && !o_pc_wr_en));

  p_ge_r8: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_cond == 4'd10) |-> (o_pass == (o_nzcv[3] == o_nzcv[0])));

  p_always_never_r9: assert property (@(posedge clk) disable iff (rst)
    i_valid |-> ((i_cond == 4'd14) ? o_pass : (i_cond == 4'd15) ? !o_pass : 1'b1));

  p_failgate_r10: assert property (@(posedge clk) disable iff (rst)
    !o_pass |-> (!o_reg_wr_en && !o_pc_wr_en));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !i_valid |-> !o_pass);

endmodule

bind nzcv_predicate nzcv_predicate_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_nzcv_predicate.sv
module test_nzcv_predicate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_valid = 1'b0, i_set_flags = 1'b0;
  logic [2:0]  i_class = '0;
  logic [3:0]  i_cond = 4'd14;
  logic [31:0] i_result = '0;
  logic        i_carry = 1'b0, i_overflow = 1'b0, i_shift_carry = 1'b0;
  logic        i_reg_wr_req = 1'b0, i_pc_wr_req = 1'b0;
  logic [3:0]  o_nzcv;
  logic        o_pass, o_reg_wr_en, o_pc_wr_en;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [3:0] model = 4'b0000;

  typedef struct {
    string      req;
    logic [3:0] nzcv;
    logic       pass, wr, pc;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  nzcv_predicate i_nzcv_predicate (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic cond_holds(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0: return z;           4'd1: return !z;
      4'd2: return cy;          4'd3: return !cy;
      4'd4: return n;           4'd5: return !n;
      4'd6: return v;           4'd7: return !v;
      4'd8: return cy && !z;    4'd9: return !cy || z;
      4'd10: return n == v;     4'd11: return n != v;
      4'd12: return !z && n == v;
      4'd13: return z || n != v;
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input string req, input logic vld, input logic [2:0] cls, input logic setf,
                       input logic [3:0] cond, input logic [31:0] res, input logic cy,
                       input logic ov, input logic sh, input logic wr, input logic pc);
    item_t it;
    logic cmp, p;
    @(negedge clk);
    i_valid = vld; i_class = cls; i_set_flags = setf; i_cond = cond; i_result = res;
    i_carry = cy; i_overflow = ov; i_shift_carry = sh; i_reg_wr_req = wr; i_pc_wr_req = pc;
    cmp = (cls >= 3'd3) && (cls <= 3'd6);
    p = vld && cond_holds(cond, model);
    it.req = req; it.pass = p; it.wr = p && wr && !cmp; it.pc = p && pc && !cmp;
    if (p && (setf || cmp)) begin
      model[3] = res[31];
      model[2] = (res == 32'd0);
      if (cls == 3'd0 || cls == 3'd4) begin model[1] = cy; model[0] = ov; end
      else if (cls == 3'd1 || cls == 3'd3) begin model[1] = !cy; model[0] = ov; end
      else model[1] = sh;
    end
    it.nzcv = model;
    q.push_back(it);
  endtask

  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        it = q[0];
        chk(it.req, "pass", 32'(o_pass), 32'(it.pass));
        chk(it.req, "reg_wr_en", 32'(o_reg_wr_en), 32'(it.wr));
        chk(it.req, "pc_wr_en", 32'(o_pc_wr_en), 32'(it.pc));
        @(posedge clk);
        #5;
        chk(it.req, "nzcv", 32'(o_nzcv), 32'(it.nzcv));
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #5 chk("R1", "reset nzcv", 32'(o_nzcv), 32'h0);
    chk("R11", "idle pass", 32'(o_pass), 32'h0);
    issue("R4", 1, 3'd0, 1, 4'd14, 32'h0000_0000, 1, 0, 0, 1, 0);
    issue("R4", 1, 3'd0, 1, 4'd14, 32'h8000_0000, 0, 1, 0, 1, 0);
    issue("R6", 1, 3'd2, 1, 4'd14, 32'h0000_0000, 0, 0, 1, 1, 0);
    issue("R5", 1, 3'd1, 1, 4'd14, 32'hFFFF_FFFF, 1, 0, 0, 1, 0);
    issue("R2", 1, 3'd0, 0, 4'd14, 32'h0000_0000, 1, 1, 1, 1, 1);
    issue("R2", 1, 3'd7, 0, 4'd14, 32'h0000_0000, 0, 0, 1, 1, 0);
    issue("R7", 1, 3'd5, 0, 4'd14, 32'h8000_0000, 0, 0, 0, 1, 1);
    issue("R7", 1, 3'd3, 0, 4'd14, 32'h0000_0000, 0, 0, 0, 1, 0);
    issue("R7", 1, 3'd4, 0, 4'd14, 32'h0000_0005, 0, 1, 1, 1, 0);
    issue("R6", 1, 3'd6, 0, 4'd14, 32'h0000_0000, 1, 0, 0, 0, 0);
    issue("R10", 1, 3'd0, 1, 4'd1, 32'h8000_0000, 1, 1, 0, 1, 1);
    issue("R10", 1, 3'd3, 0, 4'd1, 32'h8000_0000, 0, 1, 0, 0, 0);
    issue("R11", 0, 3'd0, 1, 4'd14, 32'h8000_0001, 1, 1, 1, 1, 1);
    issue("R9", 1, 3'd0, 1, 4'd15, 32'h8000_0000, 1, 1, 1, 1, 1);
    issue("R3", 1, 3'd1, 1, 4'd14, 32'h0000_0100, 0, 0, 0, 0, 0);
    for (int f = 0; f < 16; f++) begin
      logic [3:0] fv;
      fv = 4'(f);
      if (fv[3] && fv[2]) continue;
      issue("R3", 1, 3'd1, 1, 4'd14, fv[3] ? 32'h8000_0000 : (fv[2] ? 32'h0 : 32'h1),
            !fv[1], fv[0], 0, 0, 0);
      for (int c = 0; c < 16; c++)
        issue(c >= 14 ? "R9" : "R8", 1, 3'd0, 0, 4'(c), 32'h1, 0, 0, 0, 1, 1);
    end
    @(negedge clk); i_valid = 1'b0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule